// File: doc/BRIEF.md
# Boot-Strap Pin-Mux Configuration Controller

This block decides, once per reset, what the device pins do. A memory-mode code, an address-width code and a PCI-enable strap are captured on the first clock edge after the active-low reset is released, and they are then held until the next reset. From the held straps the block picks one of seven major configurations, or flags the combination as invalid. It drives function selects for four pin groups: a shared memory/video group, a 27-pin host group, a 4-pin GPIO group and a 3-pin PCI-data group.

Two mux registers show the resulting configuration. A write port lets software change only the fields that remain open after reset: the video input/output enables in the shared group, and the host-interface select when PCI is off. Every other field is held by a lock mask, so a write to it has no effect. A read returns the effective value, which is the default for locked bits and the stored value for open bits.

Top module: `pinmux_strap_ctrl`

## Requirements
- R1: The straps are captured on the first rising edge at which `rst_n` is high, and `straps_valid` reads 1 after that edge. Strap changes made after capture have no effect until the next reset.
- R2: The option code (A=0 … G=6, invalid=7) is decoded from the straps as follows. Mode 000 with PCI low selects A: mem 0, 61 GPIO. Mode 011 with PCI low selects C: mem 3, 33 GPIO. Mode 100 with PCI low selects D: mem 4, 47 GPIO. Mode 101 with PCI low selects E: mem 5, 47 GPIO. Mode 000 with PCI high selects F: mem 0, PCI, 45 GPIO. Mode 101 with PCI high selects G: mem 5, PCI, 31 GPIO. The width code is ignored for all of these options.
- R3: Mode 001 with PCI low and width code w in 0..4 selects B (code 1), with mem mode 1 and 32−2·w shared GPIO pins.
- R4: Any other combination sets the option to 7 and raises `cfg_invalid`. In that case the shared group is 61 GPIO pins with mem mode 0 and no PCI pins, and every other group reports GPIO.
- R5: `host_grp_pci`, each bit of `gpio_grp_pci` and each bit of `pcid_grp_pci` equal the effective PCI enable. The effective PCI enable is high only for options F and G.
- R6: Register 0 reads back mem mode in [2:0], video-in in [3], video-out in [4], option in [7:5] and shared GPIO count in [14:8]. Register 1 reads back the effective PCI enable in [0], host-interface select in [1] and the invalid flag in [2]. All other bits read 0.
- R7: In a valid configuration, a write to register 0 updates bits [4:3] on the write edge, and these bits drive `video_in_en` and `video_out_en`. In an invalid configuration these bits are locked at 0.
- R8: When the effective PCI enable is 0, a write to register 1 updates bit [1] (`host_grp_hostif`). When it is 1, that bit is locked at 0.
- R9: A write has no effect on locked fields. Locked fields include the PCI enable, the option, the mem mode, the GPIO count and the invalid flag.
- R10: Writes presented before `straps_valid` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_mode | input | 3 | Memory-mode strap code |
| strap_width | input | 3 | Address-width strap code |
| strap_pci | input | 1 | PCI-enable strap |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Register select for writes |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Register select for reads |
| rd_data | output | 32 | Effective value of the selected register |
| straps_valid | output | 1 | Straps have been captured |
| option | output | 3 | Major configuration code, 7 = invalid |
| cfg_invalid | output | 1 | Strap combination is not listed |
| shared_mem_mode | output | 3 | Memory pinout mode of the shared group |
| shared_pci | output | 1 | Shared group carries PCI pins |
| shared_gpio_cnt | output | 7 | GPIO pins in the shared group |
| video_in_en | output | 1 | Video input functions added to the shared group |
| video_out_en | output | 1 | Video output functions added to the shared group |
| host_grp_pci | output | 1 | Host group is PCI |
| host_grp_hostif | output | 1 | Host group is the host interface instead of GPIO |
| gpio_grp_pci | output | 4 | Per-pin PCI select, GPIO group |
| pcid_grp_pci | output | 3 | Per-pin PCI select, PCI-data group |

## Verification
The decode is exercised with every listed strap combination, once for each of the seven options. The width code is varied under options that ignore it, to show that it has no effect there. Under option B, widths 0, 2, 4 and 5 are applied, which separates the linear GPIO count from the width limit. Unlisted modes, PCI high with an unsupported mode, and strap changes after capture each check the fallback and the hold. Writes are tried with PCI on and off, with valid and invalid configurations, and during the capture cycle. These cases show the lock mask per field rather than per register.

// File: rtl/pinmux_pkg.sv
// Shared types for the strap pin-mux controller.
// Assumes option codes A..G map to 0..6 and 7 marks an unlisted strap set.
package pinmux_pkg;
    typedef enum logic [2:0] {
        OPT_A   = 3'd0,
        OPT_B   = 3'd1,
        OPT_C   = 3'd2,
        OPT_D   = 3'd3,
        OPT_E   = 3'd4,
        OPT_F   = 3'd5,
        OPT_G   = 3'd6,
        OPT_BAD = 3'd7
    } pm_option_e;

    typedef struct packed {
        pm_option_e  opt;
        logic [2:0]  mem_mode;
        logic        pci;
        logic [6:0]  gpio_cnt;
        logic        bad;
    } pm_cfg_t;
endpackage

// File: rtl/pm_strap_latch.sv
// Captures the boot straps on the first edge after reset release and holds them.
// Assumes rst_n is synchronous and active-low; no resampling until next reset.
module pm_strap_latch #(
    parameter int MODE_W  = 3,
    parameter int WIDTH_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MODE_W-1:0]  mode_i,
    input  logic [WIDTH_W-1:0] width_i,
    input  logic               pci_i,
    output logic [MODE_W-1:0]  mode_q,
    output logic [WIDTH_W-1:0] width_q,
    output logic               pci_q,
    output logic               valid_q
);
    // One-shot capture of the straps, then hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            width_q <= '0;
            pci_q   <= 1'b0;
            valid_q <= 1'b0;
        end else if (!valid_q) begin
            mode_q  <= mode_i;
            width_q <= width_i;
            pci_q   <= pci_i;
            valid_q <= 1'b1;
        end
    end
endmodule

// File: rtl/pm_option_decode.sv
// Maps held strap values to a major option and shared-group defaults.
// Assumes unlisted combinations fall back to an all-GPIO configuration.
module pm_option_decode
    import pinmux_pkg::*;
#(
    parameter int MODE_W    = 3,
    parameter int WIDTH_W   = 3,
    parameter int B_MAX_W   = 4,
    parameter int B_GPIO_HI = 32,
    parameter int ALL_GPIO  = 61
) (
    input  logic [MODE_W-1:0]  mode_i,
    input  logic [WIDTH_W-1:0] width_i,
    input  logic               pci_i,
    output pm_cfg_t            cfg_o
);
    localparam logic [6:0] GPIO_B_TOP = 7'(B_GPIO_HI);
    localparam logic [6:0] GPIO_ALL   = 7'(ALL_GPIO);

    // Combinational decode of the strap set into a configuration record.
    always_comb begin
        cfg_o = '{opt: OPT_BAD, mem_mode: 3'd0, pci: 1'b0, gpio_cnt: GPIO_ALL, bad: 1'b1};
        if (!pci_i) begin
            unique case (mode_i)
                3'd0: cfg_o = '{OPT_A, 3'd0, 1'b0, GPIO_ALL, 1'b0};
                3'd1: if (int'(width_i) <= B_MAX_W)
                          cfg_o = '{OPT_B, 3'd1, 1'b0,
                                    GPIO_B_TOP - {3'b000, width_i, 1'b0}, 1'b0};
                3'd3: cfg_o = '{OPT_C, 3'd3, 1'b0, 7'd33, 1'b0};
                3'd4: cfg_o = '{OPT_D, 3'd4, 1'b0, 7'd47, 1'b0};
                3'd5: cfg_o = '{OPT_E, 3'd5, 1'b0, 7'd47, 1'b0};
                default: ;
            endcase
        end else begin
            unique case (mode_i)
                3'd0: cfg_o = '{OPT_F, 3'd0, 1'b1, 7'd45, 1'b0};
                3'd5: cfg_o = '{OPT_G, 3'd5, 1'b1, 7'd31, 1'b0};
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pm_mux_regs.sv
// Mux register bank with per-bit lock masks.
// Locked bits read their default; open bits read stored data written by software.
// Assumes writes are only honoured once the straps are held (en_i).
module pm_mux_regs #(
    parameter int NREG   = 2,
    parameter int DATA_W = 32,
    localparam int ADDR_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           en_i,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic [NREG-1:0][DATA_W-1:0]    def_i,
    input  logic [NREG-1:0][DATA_W-1:0]    lock_i,
    output logic [NREG-1:0][DATA_W-1:0]    eff_o
);
    logic [NREG-1:0][DATA_W-1:0] store_q;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // Update only the unlocked bits of the addressed register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                store_q[g] <= '0;
            end else if (en_i && wr_en && (int'(wr_addr) == g)) begin
                store_q[g] <= (store_q[g] & lock_i[g]) | (wr_data & ~lock_i[g]);
            end
        end

        // Merge defaults for locked bits with stored open bits.
        always_comb begin
            eff_o[g] = (def_i[g] & lock_i[g]) | (store_q[g] & ~lock_i[g]);
        end
    end
endmodule

// File: rtl/pinmux_strap_ctrl.sv
// Top of the strap-latched pin-mux controller.
// Holds boot straps, decodes the major option, exposes two mux registers whose
// open fields software may change, and drives per-group function selects.
// Assumes DATA_W >= 15 so that every register field fits.
module pinmux_strap_ctrl
    import pinmux_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int GPIO_PINS = 4,
    parameter int PCID_PINS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           strap_mode,
    input  logic [2:0]           strap_width,
    input  logic                 strap_pci,
    input  logic                 wr_en,
    input  logic                 wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 straps_valid,
    output logic [2:0]           option,
    output logic                 cfg_invalid,
    output logic [2:0]           shared_mem_mode,
    output logic                 shared_pci,
    output logic [6:0]           shared_gpio_cnt,
    output logic                 video_in_en,
    output logic                 video_out_en,
    output logic                 host_grp_pci,
    output logic                 host_grp_hostif,
    output logic [GPIO_PINS-1:0] gpio_grp_pci,
    output logic [PCID_PINS-1:0] pcid_grp_pci
);
    localparam int NREG = 2;
    localparam logic [DATA_W-1:0] OPEN0 = DATA_W'(32'h18);
    localparam logic [DATA_W-1:0] OPEN1 = DATA_W'(32'h2);

    logic [2:0] mode_q, width_q;
    logic       pci_q;
    pm_cfg_t    cfg;
    logic [NREG-1:0][DATA_W-1:0] def_v, lock_v, eff_v;

    pm_strap_latch #(.MODE_W(3), .WIDTH_W(3)) u_latch (
        .clk(clk), .rst_n(rst_n),
        .mode_i(strap_mode), .width_i(strap_width), .pci_i(strap_pci),
        .mode_q(mode_q), .width_q(width_q), .pci_q(pci_q), .valid_q(straps_valid)
    );

    pm_option_decode #(.MODE_W(3), .WIDTH_W(3)) u_dec (
        .mode_i(mode_q), .width_i(width_q), .pci_i(pci_q), .cfg_o(cfg)
    );

    // Build register defaults and lock masks from the decoded option.
    always_comb begin
        def_v[0]  = '0;
        def_v[0][2:0]  = cfg.mem_mode;
        def_v[0][7:5]  = cfg.opt;
        def_v[0][14:8] = cfg.gpio_cnt;
        def_v[1]  = '0;
        def_v[1][0] = cfg.pci;
        def_v[1][2] = cfg.bad;
        lock_v[0] = cfg.bad ? '1 : ~OPEN0;
        lock_v[1] = cfg.pci ? '1 : ~OPEN1;
    end

    pm_mux_regs #(.NREG(NREG), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .en_i(straps_valid),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .def_i(def_v), .lock_i(lock_v), .eff_o(eff_v)
    );

    // Drive group selects from the effective register fields.
    always_comb begin
        rd_data         = eff_v[rd_addr];
        shared_mem_mode = eff_v[0][2:0];
        video_in_en     = eff_v[0][3];
        video_out_en    = eff_v[0][4];
        option          = eff_v[0][7:5];
        shared_gpio_cnt = eff_v[0][14:8];
        host_grp_pci    = eff_v[1][0];
        host_grp_hostif = eff_v[1][1];
        cfg_invalid     = eff_v[1][2];
        shared_pci      = eff_v[1][0];
    end

    for (genvar p = 0; p < GPIO_PINS; p++) begin : g_gpio_pin
        assign gpio_grp_pci[p] = eff_v[1][0];
    end
    for (genvar p = 0; p < PCID_PINS; p++) begin : g_pcid_pin
        assign pcid_grp_pci[p] = eff_v[1][0];
    end
endmodule

// File: rtl/pinmux_strap_ctrl_chk.sv
// Property checker bound to the pin-mux controller; observes top-level ports only.
module pinmux_strap_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        wr_addr,
    input logic [4:3]  wr_video,
    input logic        straps_valid,
    input logic [2:0]  option,
    input logic        cfg_invalid,
    input logic [2:0]  shared_mem_mode,
    input logic        shared_pci,
    input logic [6:0]  shared_gpio_cnt,
    input logic        video_in_en,
    input logic        video_out_en,
    input logic        host_grp_pci,
    input logic        host_grp_hostif
);
    // Held straps keep the option and PCI choice fixed.
    p_hold_option_r1: assert property (@(posedge clk) disable iff (!rst_n)
        straps_valid |=> ($stable(option) && $stable(host_grp_pci) && straps_valid));

    // Fallback configuration is all GPIO.
    p_fallback_gpio_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_invalid |-> (option == 3'd7 && shared_gpio_cnt == 7'd61 &&
                         shared_mem_mode == 3'd0 && !shared_pci && !host_grp_pci));

    // Only options F and G carry PCI.
    p_pci_options_r5: assert property (@(posedge clk) disable iff (!rst_n)
        host_grp_pci |-> (option == 3'd5 || option == 3'd6));

    // Video fields follow a write in a valid configuration.
    p_video_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_addr && straps_valid && !cfg_invalid) |=>
            ({video_out_en, video_in_en} == $past(wr_video)));

    // Video fields are locked low in an invalid configuration.
    p_video_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_invalid |-> (!video_in_en && !video_out_en));

    // Host-interface select is locked while PCI owns the host group.
    p_host_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        host_grp_pci |-> !host_grp_hostif);

    // Nothing is open before the straps are held.
    p_no_early_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !straps_valid |=> (!video_in_en && !video_out_en && !host_grp_hostif));
endmodule

bind pinmux_strap_ctrl pinmux_strap_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_video(wr_data[4:3]), .straps_valid(straps_valid), .option(option),
    .cfg_invalid(cfg_invalid), .shared_mem_mode(shared_mem_mode),
    .shared_pci(shared_pci), .shared_gpio_cnt(shared_gpio_cnt),
    .video_in_en(video_in_en), .video_out_en(video_out_en),
    .host_grp_pci(host_grp_pci), .host_grp_hostif(host_grp_hostif)
);

// File: tb/tb_pinmux_strap_ctrl.sv
`timescale 1ns/1ps
module tb_pinmux_strap_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  strap_mode = '0, strap_width = '0;
    logic        strap_pci = 1'b0;
    logic        wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0;
    logic [31:0] wr_data = '0, rd_data;
    logic        straps_valid, cfg_invalid, shared_pci, video_in_en, video_out_en;
    logic        host_grp_pci, host_grp_hostif;
    logic [2:0]  option, shared_mem_mode;
    logic [6:0]  shared_gpio_cnt;
    logic [3:0]  gpio_grp_pci;
    logic [2:0]  pcid_grp_pci;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pinmux_strap_ctrl dut (.*);

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // Apply straps, pulse reset, release at a falling edge; stop just after the capture edge.
    task automatic boot(input logic [2:0] m, input logic [2:0] w, input logic p);
        @(negedge clk);
        rst_n = 1'b0; strap_mode = m; strap_width = w; strap_pci = p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [31:0] d);
        rd_addr = a; #1; d = rd_data;
    endtask

    // Check decoded outputs against the expected option record.
    task automatic chk_cfg(input string req, input int opt, input int mem,
                           input logic pci, input int gcnt, input logic bad);
        chk(req, {29'b0, option}, opt);
        chk(req, {29'b0, shared_mem_mode}, mem);
        chk(req, {31'b0, shared_pci}, {31'b0, pci});
        chk(req, {25'b0, shared_gpio_cnt}, gcnt);
        chk(req, {31'b0, cfg_invalid}, {31'b0, bad});
        chk(req, {31'b0, host_grp_pci}, {31'b0, pci});
        chk(req, {28'b0, gpio_grp_pci}, pci ? 32'hF : 32'h0);
        chk(req, {29'b0, pcid_grp_pci}, pci ? 32'h7 : 32'h0);
    endtask

    task automatic t_reset_capture;
        logic [31:0] d;
        @(negedge clk);
        rst_n = 1'b0; strap_mode = 3'd4; strap_width = 3'd0; strap_pci = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset", {31'b0, straps_valid}, 0);
        rst_n = 1'b1;
        #1 chk("R1 before capture", {31'b0, straps_valid}, 0);
        @(negedge clk);
        chk("R1 after capture", {31'b0, straps_valid}, 1);
        chk_cfg("R2 option D", 3, 4, 1'b0, 47, 1'b0);
        rd(1'b0, d);
        chk("R6 reg0 D", d, 32'h2F64);
        strap_mode = 3'd2; strap_pci = 1'b1;
        repeat (3) @(negedge clk);
        chk_cfg("R1 hold", 3, 4, 1'b0, 47, 1'b0);
    endtask

    task automatic t_options;
        boot(3'd0, 3'd7, 1'b0); chk_cfg("R2 option A", 0, 0, 1'b0, 61, 1'b0);
        boot(3'd3, 3'd5, 1'b0); chk_cfg("R2 option C", 2, 3, 1'b0, 33, 1'b0);
        boot(3'd5, 3'd6, 1'b0); chk_cfg("R2 option E", 4, 5, 1'b0, 47, 1'b0);
        boot(3'd0, 3'd3, 1'b1); chk_cfg("R2 option F", 5, 0, 1'b1, 45, 1'b0);
        boot(3'd5, 3'd0, 1'b1); chk_cfg("R2 option G", 6, 5, 1'b1, 31, 1'b0);
        boot(3'd5, 3'd7, 1'b1); chk_cfg("R5 option G pci groups", 6, 5, 1'b1, 31, 1'b0);
    endtask

    task automatic t_option_b;
        for (int w = 0; w <= 4; w += 2) begin
            boot(3'd1, 3'(w), 1'b0);
            chk_cfg("R3 option B", 1, 1, 1'b0, 32 - 2 * w, 1'b0);
        end
        boot(3'd1, 3'd5, 1'b0); chk_cfg("R4 B width 5", 7, 0, 1'b0, 61, 1'b1);
    endtask

    task automatic t_invalid;
        logic [31:0] d;
        boot(3'd2, 3'd0, 1'b0); chk_cfg("R4 mode 010", 7, 0, 1'b0, 61, 1'b1);
        boot(3'd7, 3'd0, 1'b0); chk_cfg("R4 mode 111", 7, 0, 1'b0, 61, 1'b1);
        boot(3'd3, 3'd0, 1'b1); chk_cfg("R4 pci mode 011", 7, 0, 1'b0, 61, 1'b1);
        rd(1'b1, d); chk("R6 reg1 invalid", d, 32'h4);
        wr(1'b0, 32'h18);
        chk("R7 video locked invalid", {30'b0, video_out_en, video_in_en}, 0);
        wr(1'b1, 32'h2);
        chk("R8 host open invalid", {31'b0, host_grp_hostif}, 1);
    endtask

    task automatic t_writes;
        logic [31:0] d;
        boot(3'd3, 3'd0, 1'b0);
        wr(1'b0, 32'h0000_0008);
        chk("R7 video in", {30'b0, video_out_en, video_in_en}, 32'h1);
        wr(1'b0, 32'hFFFF_FFFF);
        chk("R7 video both", {30'b0, video_out_en, video_in_en}, 32'h3);
        rd(1'b0, d); chk("R9 reg0 locked fields", d, 32'h215B);
        wr(1'b1, 32'hFFFF_FFFF);
        rd(1'b1, d); chk("R9 pci bit locked", d, 32'h2);
        chk("R8 host select", {31'b0, host_grp_hostif}, 1);
        wr(1'b1, 32'h0);
        chk("R8 host clear", {31'b0, host_grp_hostif}, 0);
        boot(3'd0, 3'd0, 1'b1);
        wr(1'b1, 32'h0000_0002);
        chk("R8 host locked under pci", {31'b0, host_grp_hostif}, 0);
        wr(1'b1, 32'h0);
        rd(1'b1, d); chk("R9 pci not clearable", d, 32'h1);
    endtask

    task automatic t_early_write;
        @(negedge clk);
        rst_n = 1'b0; strap_mode = 3'd3; strap_width = '0; strap_pci = 1'b0;
        wr_en = 1'b1; wr_addr = 1'b0; wr_data = 32'h18;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R10 early write ignored", {30'b0, video_out_en, video_in_en}, 0);
    endtask

    initial begin
        t_reset_capture();
        t_options();
        t_option_b();
        t_invalid();
        t_writes();
        t_early_write();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule